// File: doc/BRIEF.md
# Clock Generator Phase-Step Sequencer

This block drives the dynamic phase-adjust port of an on-chip clock generator. Software arms it by writing to one trigger address. It then asks the clock generator for a programmed number of single phase steps, one after another. Each request presents a step strobe together with a direction bit and a field that selects which generator output is moved. The block waits for the generator's acknowledge before it releases each strobe.

The acknowledge from the generator is an active-low pulse. It falls on a rising scan-clock edge and rises again on the following falling edge, so it is low for only half a period. Logic that samples on the rising edge never sees it. The block therefore captures the acknowledge on the falling edge and hands a full-cycle flag to the rising-edge sequencer. When every step has been acknowledged, a one-cycle completion pulse re-arms the trigger and the sequencer returns to idle. A watchdog ends a step that is never acknowledged and reports an error together with completion.

Top module: `phase_step_seq`

## Requirements
- R1: While `rst_n` is low, `phase_step_o`, `seq_done_o` and `err_o` are all 0.
- R2: The block stays idle and issues no step strobe until `wr_en_i` is high with `wr_addr_i` equal to `TRIG_ADDR` (default 0x34). Writes to any other address have no effect.
- R3: Each step strobe stays high until an acknowledge has been captured, and it falls on the rising edge that follows the capture.
- R4: An acknowledge that is low only from one rising edge of `clk` to the next falling edge is captured on the falling edge and counts as one completed step.
- R5: `step_count_i` is latched when a sequence starts. Exactly that many strobes are issued, and later changes to the input have no effect on the running sequence.
- R6: A latched step count of 0 raises `seq_done_o` without issuing any strobe, and `err_o` stays 0.
- R7: After an acknowledge, the next strobe rises no earlier than `GAP_CYC` (default 2) cycles after the acknowledge was taken.
- R8: If no acknowledge is captured while a strobe has been high for `WD_LIMIT` (default 64) cycles, the strobe is released, no further steps are issued, and `err_o` rises in the same cycle as `seq_done_o`.
- R9: `seq_done_o` is high for exactly one cycle. It returns the block to idle, and a new trigger write is needed before any further strobe.
- R10: During a sequence, `phase_dir_o` and `cnt_sel_o` hold the `dir_i` and `cnt_sel_i` values that were latched at the start, even if the inputs change.
- R11: `err_o` holds its value after completion and is cleared when the next sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; the sequencer runs on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| step_count_i | input | 10 | Number of phase steps to issue |
| dir_i | input | 1 | Step direction: 1 moves the phase up, 0 moves it down |
| cnt_sel_i | input | 3 | Selects which generator output is stepped |
| pll_done_n_i | input | 1 | Active-low step acknowledge from the generator |
| phase_step_o | output | 1 | Step request strobe |
| phase_dir_o | output | 1 | Latched direction bit |
| cnt_sel_o | output | 3 | Latched output-select field |
| seq_done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Set when a step times out; cleared at the next start |

## Verification
The hardest situation to reach is the half-period acknowledge itself. A generator model in the bench pulls the acknowledge low just after a rising edge and releases it just after the next falling edge. Only falling-edge capture can see such a pulse, and rising-edge sampling would turn every step into a watchdog timeout. The timeout path is reached by switching the model into a mode that never answers. After that, a normal sequence shows that the error flag is cleared.

// File: rtl/phase_step_seq_pkg.sv
package phase_step_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_GAP  = 2'd2,
      ST_FIN  = 2'd3
   } seq_state_t;
endpackage

// File: rtl/pss_done_capture.sv
module pss_done_capture #(
   parameter bit NEG_CAPTURE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_n_i,
   output logic ack_seen_o
);
   logic ack_q;

   generate
      if (NEG_CAPTURE) begin : g_fall
         // half-period low pulse is still low at the falling edge
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) ack_q <= 1'b0;
            else        ack_q <= ~ack_n_i;
         end
      end else begin : g_rise
         // for generators whose acknowledge is held a full cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ack_q <= 1'b0;
            else        ack_q <= ~ack_n_i;
         end
      end
   endgenerate

   assign ack_seen_o = ack_q;
endmodule

// File: rtl/pss_arm.sv
module pss_arm #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned TRIG_ADDR = 'h34
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic              fin_i,
   output logic              hold_idle_o
);
   localparam logic [ADDR_W-1:0] TRIG = ADDR_W'(TRIG_ADDR);

   generate
      if (TRIG_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_addr
         $error("TRIG_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   logic hit;
   assign hit = wr_en_i && (wr_addr_i == TRIG);

   // completion wins over a coincident trigger write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hold_idle_o <= 1'b1;
      else if (fin_i) hold_idle_o <= 1'b1;
      else if (hit)   hold_idle_o <= 1'b0;
   end
endmodule

// File: rtl/pss_step_fsm.sv
module pss_step_fsm
   import phase_step_seq_pkg::*;
#(
   parameter int unsigned CNT_W    = 10,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned WD_LIMIT = 64,
   parameter int unsigned GAP_CYC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_idle_i,
   input  logic             ack_seen_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             dir_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             step_o,
   output logic             dir_o,
   output logic [SEL_W-1:0] sel_o,
   output logic             fin_o,
   output logic             err_o
);
   localparam int unsigned WD_W  = $clog2(WD_LIMIT + 1);
   localparam int unsigned GAP_W = $clog2(GAP_CYC + 1);
   localparam logic [WD_W-1:0]  WD_LAST  = WD_W'(WD_LIMIT - 1);
   localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   generate
      if (WD_LIMIT < 2) begin : g_bad_wd
         $error("WD_LIMIT must be at least 2");
      end
      if (GAP_CYC < 2) begin : g_bad_gap
         $error("GAP_CYC must be at least 2");
      end
      if (CNT_W < 1 || SEL_W < 1) begin : g_bad_w
         $error("CNT_W and SEL_W must be positive");
      end
   endgenerate

   seq_state_t       state;
   logic [CNT_W-1:0] remain;
   logic [WD_W-1:0]  wd_cnt;
   logic [GAP_W-1:0] gap_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         remain  <= '0;
         wd_cnt  <= '0;
         gap_cnt <= '0;
         step_o  <= 1'b0;
         dir_o   <= 1'b0;
         sel_o   <= '0;
         err_o   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (!hold_idle_i) begin
                  dir_o <= dir_i;
                  sel_o <= sel_i;
                  err_o <= 1'b0;
                  if (count_i == '0) begin
                     state <= ST_FIN;
                  end else begin
                     remain <= count_i;
                     wd_cnt <= '0;
                     step_o <= 1'b1;
                     state  <= ST_REQ;
                  end
               end
            end
            ST_REQ: begin
               if (ack_seen_i) begin
                  step_o <= 1'b0;
                  if (remain == CNT_ONE) begin
                     state <= ST_FIN;
                  end else begin
                     remain  <= remain - CNT_ONE;
                     gap_cnt <= '0;
                     state   <= ST_GAP;
                  end
               end else if (wd_cnt == WD_LAST) begin
                  step_o <= 1'b0;
                  err_o  <= 1'b1;
                  state  <= ST_FIN;
               end else begin
                  wd_cnt <= wd_cnt + 1'b1;
               end
            end
            ST_GAP: begin
               if (ack_seen_i) begin
                  gap_cnt <= '0;
               end else if (gap_cnt == GAP_LAST) begin
                  wd_cnt <= '0;
                  step_o <= 1'b1;
                  state  <= ST_REQ;
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            ST_FIN: begin
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign fin_o = (state == ST_FIN);
endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned TRIG_ADDR   = 'h34,
   parameter int unsigned CNT_W       = 10,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned WD_LIMIT    = 64,
   parameter int unsigned GAP_CYC     = 2,
   parameter bit          NEG_CAPTURE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [CNT_W-1:0]  step_count_i,
   input  logic              dir_i,
   input  logic [SEL_W-1:0]  cnt_sel_i,
   input  logic              pll_done_n_i,
   output logic              phase_step_o,
   output logic              phase_dir_o,
   output logic [SEL_W-1:0]  cnt_sel_o,
   output logic              seq_done_o,
   output logic              err_o
);
   logic hold_idle;
   logic done_seen;

   pss_done_capture #(.NEG_CAPTURE(NEG_CAPTURE)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .ack_n_i    (pll_done_n_i),
      .ack_seen_o (done_seen)
   );

   pss_arm #(.ADDR_W(ADDR_W), .TRIG_ADDR(TRIG_ADDR)) u_arm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (wr_en_i),
      .wr_addr_i   (wr_addr_i),
      .fin_i       (seq_done_o),
      .hold_idle_o (hold_idle)
   );

   pss_step_fsm #(
      .CNT_W(CNT_W), .SEL_W(SEL_W), .WD_LIMIT(WD_LIMIT), .GAP_CYC(GAP_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_idle_i (hold_idle),
      .ack_seen_i  (done_seen),
      .count_i     (step_count_i),
      .dir_i       (dir_i),
      .sel_i       (cnt_sel_i),
      .step_o      (phase_step_o),
      .dir_o       (phase_dir_o),
      .sel_o       (cnt_sel_o),
      .fin_o       (seq_done_o),
      .err_o       (err_o)
   );
endmodule

// File: rtl/phase_step_seq_chk.sv
module phase_step_seq_chk #(
   parameter int unsigned WD_LIMIT = 64,
   parameter int unsigned GAP_CYC  = 2
) (
   input logic clk,
   input logic rst_n,
   input logic step,
   input logic seq_done,
   input logic err,
   input logic done_seen
);
   localparam int unsigned RUN_W  = $clog2(WD_LIMIT + 2);
   localparam int unsigned SINCE_W = $clog2(GAP_CYC + 1);
   localparam logic [RUN_W-1:0]   RUN_MAX   = RUN_W'(WD_LIMIT + 1);
   localparam logic [RUN_W-1:0]   RUN_LIM   = RUN_W'(WD_LIMIT);
   localparam logic [SINCE_W-1:0] SINCE_MAX = SINCE_W'(GAP_CYC);

   logic [RUN_W-1:0]   high_run;
   logic [SINCE_W-1:0] since_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               high_run <= '0;
      else if (!step)           high_run <= '0;
      else if (high_run != RUN_MAX) high_run <= high_run + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  since_ack <= SINCE_MAX;
      else if (done_seen)          since_ack <= '0;
      else if (since_ack != SINCE_MAX) since_ack <= since_ack + 1'b1;
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!step && !seq_done && !err));

   p_release_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(step) |-> ($past(done_seen) || err));

   p_gap_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step) |-> (since_ack >= SINCE_MAX));

   p_strobe_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      high_run <= RUN_LIM);

   p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> seq_done);

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

   p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !step);
endmodule

bind phase_step_seq phase_step_seq_chk #(
   .WD_LIMIT(WD_LIMIT), .GAP_CYC(GAP_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .step      (phase_step_o),
   .seq_done  (seq_done_o),
   .err       (err_o),
   .done_seen (done_seen)
);

// File: tb/phase_step_seq_tb.sv
module phase_step_seq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [9:0] step_count = '0;
   logic       dir_in = 1'b0;
   logic [2:0] sel_in = '0;
   logic       ack_n = 1'b1;
   logic       step, dir_out, seq_done, err;
   logic [2:0] sel_out;

   int compared = 0;
   int mismatched = 0;
   int steps_seen = 0;
   int bad_field = 0;
   int done_count = 0;
   bit stall = 1'b0;
   int lat = 1;
   bit cur_dir = 1'b0;
   logic [2:0] cur_sel = '0;

   typedef struct {
      int steps;
      bit err;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   phase_step_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .step_count_i(step_count), .dir_i(dir_in), .cnt_sel_i(sel_in),
      .pll_done_n_i(ack_n), .phase_step_o(step), .phase_dir_o(dir_out),
      .cnt_sel_o(sel_out), .seq_done_o(seq_done), .err_o(err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // step counter and field monitor, sampled after the rising edge settles
   bit prev_step = 1'b0;
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (step && !prev_step) begin
            steps_seen++;
            if (dir_out !== cur_dir || sel_out !== cur_sel) bad_field++;
         end
         prev_step = step;
      end
   end

   // clock generator model: half-period active-low acknowledge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (step && !stall) begin
            repeat (lat) @(posedge clk);
            #1 ack_n = 1'b0;
            @(negedge clk);
            #1 ack_n = 1'b1;
            do begin
               @(posedge clk);
               #2;
            end while (step);
         end
      end
   end

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (seq_done) begin
            exp_t e;
            if (sb.size() == 0) begin
               check(1'b0, "R9 unexpected completion", 1, 0);
            end else begin
               e = sb.pop_front();
               check(steps_seen == e.steps, "R5 step count", steps_seen, e.steps);
               check(err == e.err, "R8 err flag at completion", err, e.err);
               check(bad_field == 0, "R10 dir/sel held", bad_field, 0);
            end
            done_count++;
         end
      end
   end

   task automatic trigger(input logic [7:0] addr);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = addr;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_seq(input int cnt, input bit d, input logic [2:0] s,
                          input int exp_steps, input bit exp_err, input bit perturb);
      int target;
      exp_t e;
      steps_seen = 0;
      bad_field = 0;
      step_count = 10'(cnt);
      dir_in = d;
      sel_in = s;
      cur_dir = d;
      cur_sel = s;
      e.steps = exp_steps;
      e.err = exp_err;
      sb.push_back(e);
      target = done_count + 1;
      trigger(8'h34);
      if (perturb) begin
         repeat (3) @(negedge clk);
         step_count = 10'd1;   // R5: ignored after latch
         dir_in = ~d;          // R10: ignored after latch
         sel_in = ~s;
      end
      while (done_count < target) @(negedge clk);
   endtask

   bit finished = 1'b0;
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog expired", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      #3 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(step == 1'b0, "R1 strobe in reset", step, 0);
      check(seq_done == 1'b0, "R1 done in reset", seq_done, 0);
      check(err == 1'b0, "R1 err in reset", err, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: a write to another address does not start anything
      step_count = 10'd3;
      trigger(8'h35);
      repeat (20) @(negedge clk);
      check(steps_seen == 0, "R2 foreign address ignored", steps_seen, 0);
      check(step == 1'b0, "R2 strobe idle", step, 0);

      // R3 R4: normal sequence with half-period acknowledges
      run_seq(3, 1'b1, 3'd2, 3, 1'b0, 1'b0);

      // R9: no further strobes without a new trigger
      repeat (20) @(negedge clk);
      check(steps_seen == 3, "R9 idle after completion", steps_seen, 3);

      // R6: zero count
      run_seq(0, 1'b0, 3'd1, 0, 1'b0, 1'b0);

      // R5 R10: inputs change during the run
      run_seq(5, 1'b0, 3'd5, 5, 1'b0, 1'b1);

      // R7 with longer generator latency
      lat = 3;
      run_seq(2, 1'b1, 3'd7, 2, 1'b0, 1'b0);
      lat = 1;

      // R8: generator never answers
      stall = 1'b1;
      run_seq(4, 1'b1, 3'd3, 1, 1'b1, 1'b0);
      stall = 1'b0;
      repeat (5) @(negedge clk);
      check(err == 1'b1, "R11 err held after completion", err, 1);
      check(step == 1'b0, "R8 strobe released after timeout", step, 0);

      // R11: next start clears the error
      run_seq(1, 1'b0, 3'd4, 1, 1'b0, 1'b0);
      check(err == 1'b0, "R11 err cleared by new start", err, 0);

      repeat (5) @(negedge clk);
      check(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule